// File: doc/BRIEF.md
# Shared Frame-Buffer Bus Arbiter

This block decides who drives a single local SRAM address/data bus: a video scan-out engine or an external host processor whose writes pass through bus transceivers. The scan engine raises `scan_req` while it needs the memory and lowers it during its blanking intervals. The arbiter answers with three registered controls: an active-low SRAM output enable, an active-low transceiver enable, and a grant that hands the bus to a host write controller.

Every change of owner passes through timed turnaround states. Each state holds for a fixed number of clocks, so one driver has let go of the bus before the other starts driving it. Going to the host, the SRAM outputs are turned off first. After a wait, the transceivers are turned on. After a second wait, the grant is given. Going back, the grant and the transceivers are dropped together. After a wait, the SRAM outputs are turned on again. A final settle wait follows before the scan engine is considered to own the bus. The length of every wait is set by one parameter.

Top module: `fb_bus_arbiter`

## Requirements
- R1: While `rst` is high and just after it is released, `sram_oe_n` = 1, `xcvr_en_n` = 1 and `host_grant` = 0, and the arbiter is in the scan-owned state.
- R2: In the scan-owned state, an edge that samples `scan_req` = 0 sets `sram_oe_n` to 1 and starts the first tri-state wait. While `scan_req` stays 1, nothing changes.
- R3: The first tri-state wait lasts WAIT_CYC+1 clocks. At its final edge, if `scan_req` = 0, `xcvr_en_n` falls to 0 and the buffer wait starts.
- R4: The buffer wait lasts WAIT_CYC+1 clocks. At its final edge, if `scan_req` = 0, `host_grant` rises to 1 and the host-owned state starts.
- R5: In the host-owned state, the first edge that samples `scan_req` = 1 drops `host_grant` to 0 and sets `xcvr_en_n` to 1 on that same edge, then starts the second tri-state wait. While `scan_req` stays 0, the grant is held.
- R6: The second tri-state wait lasts WAIT_CYC+1 clocks and ends by setting `sram_oe_n` to 0. A settle wait of WAIT_CYC+1 clocks follows, and `scan_req` is ignored during both waits. A low `scan_req` therefore raises `sram_oe_n` again no earlier than WAIT_CYC+2 edges after it fell.
- R7: If `scan_req` = 1 at the final edge of the first tri-state wait, the buffer wait and the host-owned state are skipped. The arbiter goes straight to the second tri-state wait, with `xcvr_en_n` left at 1 and `host_grant` left at 0.
- R8: If `scan_req` = 1 at the final edge of the buffer wait, `xcvr_en_n` returns to 1, no grant is given, and the second tri-state wait starts.
- R9: `host_grant` is 1 only in the host-owned state, which means `xcvr_en_n` = 0 and `sram_oe_n` = 1 whenever it is 1. `sram_oe_n` and `xcvr_en_n` are never both 0.
- R10: The turnaround length WAIT_CYC is a parameter (at least 1, default 5), and every wait state lasts exactly WAIT_CYC+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_req | input | 1 | Scan engine needs the bus (1) or yields it (0) |
| sram_oe_n | output | 1 | SRAM data output enable, active low |
| xcvr_en_n | output | 1 | Host bus transceiver enable, active low |
| host_grant | output | 1 | Bus granted to the host write controller |

## Verification
A wrong state or a wrong wait count shows at the ports as an edge of `sram_oe_n`, `xcvr_en_n` or `host_grant` one or more clocks early or late. It can also show as a grant that appears while the transceivers are off, or as both bus drivers enabled at once. All three outputs are registered, so a corrupted transition shows up on the edge that takes it, and a miscounted wait shows up at the end of that wait, within WAIT_CYC+1 clocks. The bench compares every cycle against its own model for two wait lengths, so both the timing of each edge and the grant invariant are checked cycle by cycle.

// File: rtl/fb_arb_pkg.sv
package fb_arb_pkg;

   typedef enum logic [2:0] {
      ST_SCAN = 3'd0,
      ST_TRI1 = 3'd1,
      ST_BUFW = 3'd2,
      ST_HOST = 3'd3,
      ST_TRI2 = 3'd4,
      ST_SETL = 3'd5
   } arb_state_e;

   function automatic logic is_wait_state(arb_state_e st);
      return (st == ST_TRI1) || (st == ST_BUFW) ||
             (st == ST_TRI2) || (st == ST_SETL);
   endfunction

endpackage

// File: rtl/fb_turn_timer.sv
module fb_turn_timer #(
   parameter int WAIT_CYC = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   input  logic run,
   output logic done
);
   localparam int CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYC);

   logic [CW-1:0] cnt_q;

   generate
      if (WAIT_CYC < 1) begin : g_bad_wait
         $error("fb_turn_timer: WAIT_CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         cnt_q <= '0;
      end else if (run && (cnt_q != LIMIT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = (cnt_q == LIMIT);

   // R10: the count never passes the configured limit
   assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LIMIT);

   // R10: a restart always brings the count back to zero
   assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
      restart |=> (cnt_q == '0));

endmodule

// File: rtl/fb_handover_fsm.sv
module fb_handover_fsm
   import fb_arb_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       scan_req,
   input  logic       wait_done,
   output arb_state_e state,
   output arb_state_e nxt_state,
   output logic       restart,
   output logic       run
);
   arb_state_e st_q;

   always_comb begin
      nxt_state = st_q;
      unique case (st_q)
         ST_SCAN: if (!scan_req) nxt_state = ST_TRI1;
         ST_TRI1: if (wait_done) nxt_state = scan_req ? ST_TRI2 : ST_BUFW;
         ST_BUFW: if (wait_done) nxt_state = scan_req ? ST_TRI2 : ST_HOST;
         ST_HOST: if (scan_req)  nxt_state = ST_TRI2;
         ST_TRI2: if (wait_done) nxt_state = ST_SETL;
         ST_SETL: if (wait_done) nxt_state = ST_SCAN;
         default: nxt_state = ST_SCAN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_SCAN;
      else     st_q <= nxt_state;
   end

   assign state   = st_q;
   assign restart = (nxt_state != st_q);
   assign run     = is_wait_state(st_q);

   // R3 R4 R6: a wait state is left only when its timer has expired
   assert_wait_exit_R3: assert property (@(posedge clk) disable iff (rst)
      (is_wait_state(st_q) && (nxt_state != st_q)) |-> wait_done);

   // R2: the scan-owned state holds while the engine keeps requesting
   assert_scan_hold_R2: assert property (@(posedge clk) disable iff (rst)
      ((st_q == ST_SCAN) && scan_req) |=> (st_q == ST_SCAN));

endmodule

// File: rtl/fb_bus_drive.sv
module fb_bus_drive
   import fb_arb_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  arb_state_e state,
   input  arb_state_e nxt_state,
   input  logic       scan_req,
   output logic       sram_oe_n,
   output logic       xcvr_en_n,
   output logic       host_grant
);
   logic oe_n_q;
   logic xe_n_q;
   logic gnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         oe_n_q <= 1'b1;
         xe_n_q <= 1'b1;
         gnt_q  <= 1'b0;
      end else if (nxt_state != state) begin
         unique case (state)
            ST_SCAN: oe_n_q <= 1'b1;
            ST_TRI1: if (nxt_state == ST_BUFW) xe_n_q <= 1'b0;
            ST_BUFW: begin
               if (nxt_state == ST_HOST) gnt_q  <= 1'b1;
               else                      xe_n_q <= 1'b1;
            end
            ST_HOST: begin
               gnt_q  <= 1'b0;
               xe_n_q <= 1'b1;
            end
            ST_TRI2: oe_n_q <= 1'b0;
            default: ;
         endcase
      end
   end

   assign sram_oe_n  = oe_n_q;
   assign xcvr_en_n  = xe_n_q;
   assign host_grant = gnt_q;

   // R9: the grant exists only while the host owns the bus
   assert_grant_host_R9: assert property (@(posedge clk) disable iff (rst)
      gnt_q |-> (state == ST_HOST));

   // R9: SRAM outputs and transceivers never drive together
   assert_no_contention_R9: assert property (@(posedge clk) disable iff (rst)
      !(!oe_n_q && !xe_n_q));

   // R5: a request in the host-owned state releases grant and buffers together
   assert_release_R5: assert property (@(posedge clk) disable iff (rst)
      ((state == ST_HOST) && scan_req) |=> (!gnt_q && xe_n_q));

endmodule

// File: rtl/fb_bus_arbiter.sv
module fb_bus_arbiter
   import fb_arb_pkg::*;
#(
   parameter int WAIT_CYC = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic scan_req,
   output logic sram_oe_n,
   output logic xcvr_en_n,
   output logic host_grant
);
   arb_state_e state;
   arb_state_e nxt_state;
   logic       restart;
   logic       run;
   logic       wait_done;

   fb_handover_fsm u_fsm (
      .clk       (clk),
      .rst       (rst),
      .scan_req  (scan_req),
      .wait_done (wait_done),
      .state     (state),
      .nxt_state (nxt_state),
      .restart   (restart),
      .run       (run)
   );

   fb_turn_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .run     (run),
      .done    (wait_done)
   );

   fb_bus_drive u_drive (
      .clk        (clk),
      .rst        (rst),
      .state      (state),
      .nxt_state  (nxt_state),
      .scan_req   (scan_req),
      .sram_oe_n  (sram_oe_n),
      .xcvr_en_n  (xcvr_en_n),
      .host_grant (host_grant)
   );

   // R7: a late request at the end of the first wait skips straight to release
   assert_skip_R7: assert property (@(posedge clk) disable iff (rst)
      ((state == ST_TRI1) && wait_done && scan_req) |=>
         ((state == ST_TRI2) && xcvr_en_n && !host_grant));

   // R8: a late request at the end of the buffer wait withdraws the buffers
   assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
      ((state == ST_BUFW) && wait_done && scan_req) |=>
         ((state == ST_TRI2) && xcvr_en_n && !host_grant));

endmodule

// File: tb/fb_bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module fb_bus_arbiter_tb_top;

   localparam int W1 = 5;
   localparam int W2 = 2;

   typedef struct {
      int st;
      int cnt;
      bit oe;
      bit xe;
      bit gr;
   } mdl_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic scan_req = 1'b1;
   logic oe1, xe1, gr1, oe2, xe2, gr2;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   finished = 1'b0;
   mdl_t m1, m2;

   always #2 clk = ~clk;

   fb_bus_arbiter #(.WAIT_CYC(W1)) dut_i (
      .clk(clk), .rst(rst), .scan_req(scan_req),
      .sram_oe_n(oe1), .xcvr_en_n(xe1), .host_grant(gr1));

   fb_bus_arbiter #(.WAIT_CYC(W2)) dut2_i (
      .clk(clk), .rst(rst), .scan_req(scan_req),
      .sram_oe_n(oe2), .xcvr_en_n(xe2), .host_grant(gr2));

   // states: 0 scan, 1 tri-wait 1, 2 buffer wait, 3 host, 4 tri-wait 2, 5 settle
   function automatic mdl_t mdl_reset();
      mdl_t m;
      m.st = 0; m.cnt = 0; m.oe = 1'b1; m.xe = 1'b1; m.gr = 1'b0;
      return m;
   endfunction

   function automatic mdl_t mdl_step(mdl_t m, bit req, int w);
      mdl_t n = m;
      case (m.st)
         0: if (!req) begin n.oe = 1'b1; n.st = 1; n.cnt = 0; end
         1: if (m.cnt == w) begin
               n.cnt = 0;
               if (req) n.st = 4;
               else begin n.xe = 1'b0; n.st = 2; end
            end else n.cnt = m.cnt + 1;
         2: if (m.cnt == w) begin
               n.cnt = 0;
               if (req) begin n.xe = 1'b1; n.st = 4; end
               else begin n.gr = 1'b1; n.st = 3; end
            end else n.cnt = m.cnt + 1;
         3: if (req) begin n.gr = 1'b0; n.xe = 1'b1; n.cnt = 0; n.st = 4; end
         4: if (m.cnt == w) begin n.oe = 1'b0; n.cnt = 0; n.st = 5; end
            else n.cnt = m.cnt + 1;
         default: if (m.cnt == w) begin n.cnt = 0; n.st = 0; end
                  else n.cnt = m.cnt + 1;
      endcase
      return n;
   endfunction

   function automatic string mdl_tag(mdl_t m, bit req, int w);
      case (m.st)
         0: return "R2";
         1: return (m.cnt == w && req) ? "R7" : "R3";
         2: return (m.cnt == w && req) ? "R8" : "R4";
         3: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(bit ok, string rq, string what, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic cycle(input bit req);
      string t1;
      string t2;
      scan_req = req;
      t1 = mdl_tag(m1, req, W1);
      t2 = mdl_tag(m2, req, W2);
      @(posedge clk);
      m1 = mdl_step(m1, req, W1);
      m2 = mdl_step(m2, req, W2);
      @(negedge clk);
      check({oe1, xe1, gr1} == {m1.oe, m1.xe, m1.gr}, t1, "outputs {oe,xe,gnt}",
            int'({oe1, xe1, gr1}), int'({m1.oe, m1.xe, m1.gr}));
      check({oe2, xe2, gr2} == {m2.oe, m2.xe, m2.gr}, {t2, "/R10"}, "short-wait outputs",
            int'({oe2, xe2, gr2}), int'({m2.oe, m2.xe, m2.gr}));
      check(!(gr1 && (xe1 || !oe1)) && (oe1 || xe1), "R9", "grant/contention invariant",
            int'({oe1, xe1, gr1}), 3'b100);
      check(!(gr2 && (xe2 || !oe2)) && (oe2 || xe2), "R9", "short-wait invariant",
            int'({oe2, xe2, gr2}), 3'b100);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1 (run completed)");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      bit bad;
      void'($urandom(32'd4711));
      m1 = mdl_reset();
      m2 = mdl_reset();
      rst = 1'b1;
      scan_req = 1'b1;
      repeat (3) @(negedge clk);
      // R1: reset values
      check({oe1, xe1, gr1} == 3'b110, "R1", "reset outputs", int'({oe1, xe1, gr1}), 3'b110);
      rst = 1'b0;
      cycle(1'b1);
      check({oe1, xe1, gr1} == 3'b110, "R1", "after release", int'({oe1, xe1, gr1}), 3'b110);

      // full handover to the host and back
      repeat (20) cycle(1'b0);
      check(gr1 == 1'b1, "R4", "grant held in host state", gr1, 1);
      cycle(1'b1);
      check(!gr1 && xe1, "R5", "grant and buffers drop together", int'({xe1, gr1}), 2);
      n = 0;
      while (oe1 && n < 50) begin cycle(1'b1); n++; end
      check(n == W1 + 1, "R6", "tri-state wait 2 length", n, W1 + 1);

      // R6: a low request during settle waits for settle to finish
      n = 0;
      while (!oe1 && n < 50) begin cycle(1'b0); n++; end
      check(n == W1 + 2, "R6", "settle blocks early request", n, W1 + 2);

      // R3: first tri-state wait length
      n = 0;
      while (xe1 && n < 50) begin cycle(1'b0); n++; end
      check(n == W1 + 1, "R3", "tri-state wait 1 length", n, W1 + 1);
      // R4: buffer wait length
      n = 0;
      while (!gr1 && n < 50) begin cycle(1'b0); n++; end
      check(n == W1 + 1, "R4", "buffer wait length", n, W1 + 1);
      repeat (30) cycle(1'b1);

      // R7: request returns before the first wait ends
      cycle(1'b0);
      bad = 1'b0;
      for (int i = 0; i < 30; i++) begin
         cycle(1'b1);
         if (!xe1 || gr1) bad = 1'b1;
      end
      check(!bad, "R7", "no buffers or grant on skip", int'(bad), 0);
      check(!oe1, "R7", "SRAM re-enabled after skip", oe1, 0);

      // R8: request returns during the buffer wait
      repeat (W1 + 2) cycle(1'b0);
      check(!xe1, "R8", "buffers on in buffer wait", xe1, 0);
      bad = 1'b0;
      for (int i = 0; i < 30; i++) begin
         cycle(1'b1);
         if (gr1) bad = 1'b1;
      end
      check(!bad && xe1, "R8", "no grant after abort", int'({bad, xe1}), 1);

      // R2: scan state holds while requested
      bad = 1'b0;
      for (int i = 0; i < 10; i++) begin
         cycle(1'b1);
         if (oe1) bad = 1'b1;
      end
      check(!bad, "R2", "scan state holds", int'(bad), 0);

      // constrained random: runs of random length
      for (int k = 0; k < 600; k++) begin
         bit v = 1'($urandom_range(0, 1));
         int len = $urandom_range(1, 16);
         for (int j = 0; j < len; j++) cycle(v);
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule